// File: doc/BRIEF.md
# Extended-Precision Compare Unit

This block orders two 80-bit extended-precision floating-point values. Each value has a sign bit at bit 79, a 15-bit biased exponent in bits 78:64, and a 64-bit significand in bits 63:0 whose top bit is an explicit integer bit. The compare itself is combinational. When an operation is presented, the ordering is encoded into three condition bits of a 16-bit status word. That word is registered together with a register-stack pop count.

The caller supplies the current status word on `status_in` and a mode code. The block returns the updated word on `status_q` one clock after the request. All bits outside the condition field are copied unchanged from `status_in`. Besides the two-operand compare, a test mode orders the first operand against positive zero. The pop count tells the surrounding register stack how many entries to discard after the compare.

Top module: `fcmp_status_unit`

## Requirements
- R1: After reset, `status_q` is 16'h0000 and `pop_q` is 0.
- R2: When operand A is less than operand B, the updated word has bit 8 set and bits 10 and 14 clear.
- R3: When the operands are equal, only bit 14 of the condition field is set. Positive zero and negative zero count as equal.
- R4: When operand A is greater than operand B, bits 8, 10 and 14 are all clear.
- R5: An operand is a NaN when its exponent is 15'h7FFF and significand bits 62:0 are nonzero. If either operand is a NaN, bits 8, 10 and 14 are all set. An infinity (exponent all ones, bits 62:0 zero) is an ordinary ordered value.
- R6: Ordered non-zero values are ranked first by sign, then by exponent, then by significand. When both operands are negative, the magnitude order is reversed.
- R7: Mode 3 (test) compares operand A against +0 using the same encoding. `opb` has no effect in this mode.
- R8: The pop count is 0 for mode 0, 1 for mode 1, 2 for mode 2 and 0 for mode 3. It appears on `pop_q` in the cycle after the request and is 0 in any cycle that follows no request.
- R9: On a request, every status bit other than 8, 10 and 14 is taken from `status_in`.
- R10: In cycles without a request, `status_q` holds its value whatever `status_in` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_valid | input | 1 | Request strobe for one compare |
| cmp_mode | input | 2 | 0 compare, 1 compare+pop, 2 compare+double pop, 3 test against zero |
| opa | input | 80 | First operand |
| opb | input | 80 | Second operand (ignored in mode 3) |
| status_in | input | 16 | Current status word to be updated |
| status_q | output | 16 | Registered updated status word |
| pop_q | output | 2 | Registered stack pop count |

## Verification
The vector table pairs values that differ only in sign, only in exponent, or only in significand, so each step of the ranking chain is tested on its own. Negative pairs are included to show whether the magnitude order is reversed. Signed zeros show whether zero is special-cased, and an infinity next to a quiet NaN shows whether the NaN test looks at the fraction bits below the integer bit. Test-mode vectors use a NaN or an ordered value on `opb` to show that it is ignored. A varying `status_in` pattern exposes any condition bit placed at the wrong position and any lost surrounding bit.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
    localparam int SW_W   = 16;
    localparam int C0_POS = 8;
    localparam int C2_POS = 10;
    localparam int C3_POS = 14;
    localparam logic [SW_W-1:0] COND_MASK =
        (SW_W'(1) << C0_POS) | (SW_W'(1) << C2_POS) | (SW_W'(1) << C3_POS);

    typedef enum logic [1:0] {
        REL_GT = 2'd0,
        REL_LT = 2'd1,
        REL_EQ = 2'd2,
        REL_UN = 2'd3
    } rel_e;

    typedef enum logic [1:0] {
        MODE_CMP      = 2'd0,
        MODE_CMP_POP  = 2'd1,
        MODE_CMP_POP2 = 2'd2,
        MODE_TEST     = 2'd3
    } mode_e;

    typedef struct packed {
        logic [SW_W-1:0] status;
        logic [1:0]      pop;
    } fcmp_state_t;
endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify #(
    parameter int EXP_W = 15,
    parameter int MAN_W = 64,
    localparam int VAL_W = EXP_W + MAN_W + 1,
    localparam int MAG_W = EXP_W + MAN_W
) (
    input  logic [VAL_W-1:0] val,
    output logic             sign,
    output logic             is_nan,
    output logic             is_zero,
    output logic [MAG_W-1:0] mag
);
    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-2:0] frac_f;

    always_comb begin
        sign    = val[VAL_W-1];
        exp_f   = val[MAG_W-1:MAN_W];
        frac_f  = val[MAN_W-2:0];
        mag     = val[MAG_W-1:0];
        is_nan  = (&exp_f) && (|frac_f);
        is_zero = (mag == '0);
    end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
    import fcmp_pkg::*;
#(
    parameter int MAG_W = 79
) (
    input  logic             a_sign,
    input  logic             a_nan,
    input  logic             a_zero,
    input  logic [MAG_W-1:0] a_mag,
    input  logic             b_sign,
    input  logic             b_nan,
    input  logic             b_zero,
    input  logic [MAG_W-1:0] b_mag,
    output rel_e             rel
);
    logic mag_lt, mag_eq;

    always_comb begin
        mag_lt = (a_mag < b_mag);
        mag_eq = (a_mag == b_mag);
        if (a_nan || b_nan)
            rel = REL_UN;
        else if (a_zero && b_zero)
            rel = REL_EQ;
        else if (a_sign != b_sign)
            rel = a_sign ? REL_LT : REL_GT;
        else if (mag_eq)
            rel = REL_EQ;
        else if (mag_lt ^ a_sign)
            rel = REL_LT;
        else
            rel = REL_GT;
    end
endmodule

// File: rtl/fcmp_status_unit.sv
module fcmp_status_unit
    import fcmp_pkg::*;
#(
    parameter int EXP_W = 15,
    parameter int MAN_W = 64,
    localparam int VAL_W = EXP_W + MAN_W + 1,
    localparam int MAG_W = EXP_W + MAN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_valid,
    input  logic [1:0]       cmp_mode,
    input  logic [VAL_W-1:0] opa,
    input  logic [VAL_W-1:0] opb,
    input  logic [SW_W-1:0]  status_in,
    output logic [SW_W-1:0]  status_q,
    output logic [1:0]       pop_q
);
    localparam int N_OPS = 2;

    logic [VAL_W-1:0] op_sel  [N_OPS];
    logic             op_sign [N_OPS];
    logic             op_nan  [N_OPS];
    logic             op_zero [N_OPS];
    logic [MAG_W-1:0] op_mag  [N_OPS];

    mode_e       mode;
    rel_e        rel;
    fcmp_state_t st_d, st_q;
    logic [SW_W-1:0] cond_bits;

    assign mode      = mode_e'(cmp_mode);
    assign op_sel[0] = opa;
    assign op_sel[1] = (mode == MODE_TEST) ? '0 : opb;

    for (genvar g = 0; g < N_OPS; g++) begin : g_cls
        fcmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
            .val     (op_sel[g]),
            .sign    (op_sign[g]),
            .is_nan  (op_nan[g]),
            .is_zero (op_zero[g]),
            .mag     (op_mag[g])
        );
    end

    fcmp_order #(.MAG_W(MAG_W)) u_order (
        .a_sign (op_sign[0]),
        .a_nan  (op_nan[0]),
        .a_zero (op_zero[0]),
        .a_mag  (op_mag[0]),
        .b_sign (op_sign[1]),
        .b_nan  (op_nan[1]),
        .b_zero (op_zero[1]),
        .b_mag  (op_mag[1]),
        .rel    (rel)
    );

    always_comb begin
        cond_bits = '0;
        unique case (rel)
            REL_LT:  cond_bits[C0_POS] = 1'b1;
            REL_EQ:  cond_bits[C3_POS] = 1'b1;
            REL_UN:  cond_bits = COND_MASK;
            default: cond_bits = '0;
        endcase

        st_d     = st_q;
        st_d.pop = 2'd0;
        if (cmp_valid) begin
            st_d.status = (status_in & ~COND_MASK) | cond_bits;
            unique case (mode)
                MODE_CMP_POP:  st_d.pop = 2'd1;
                MODE_CMP_POP2: st_d.pop = 2'd2;
                default:       st_d.pop = 2'd0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_q = st_q.status;
    assign pop_q    = st_q.pop;

    // R5
    nan_sets_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && (op_nan[0] || op_nan[1])) |=>
        (status_q[C0_POS] && status_q[C2_POS] && status_q[C3_POS]));

    // R5
    c2_only_unordered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status_q[C2_POS] |-> (status_q[C0_POS] && status_q[C3_POS]));

    // R9
    keep_other_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |=> ((status_q & ~COND_MASK) == ($past(status_in) & ~COND_MASK)));

    // R10
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_valid |=> $stable(status_q));

    // R8
    pop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_valid |=> (pop_q == 2'd0));

    // R8
    pop_double_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && cmp_mode == 2'd2) |=> (pop_q == 2'd2));
endmodule

// File: tb/tb_fcmp_status_unit.sv
module tb_fcmp_status_unit;
    localparam time CLK_PERIOD = 10ns;

    localparam logic [79:0] P_ONE  = {1'b0, 15'h3FFF, 64'h8000_0000_0000_0000};
    localparam logic [79:0] N_ONE  = {1'b1, 15'h3FFF, 64'h8000_0000_0000_0000};
    localparam logic [79:0] P_TWO  = {1'b0, 15'h4000, 64'h8000_0000_0000_0000};
    localparam logic [79:0] N_TWO  = {1'b1, 15'h4000, 64'h8000_0000_0000_0000};
    localparam logic [79:0] P_1P5  = {1'b0, 15'h3FFF, 64'hC000_0000_0000_0000};
    localparam logic [79:0] N_1P5  = {1'b1, 15'h3FFF, 64'hC000_0000_0000_0000};
    localparam logic [79:0] P_ZERO = 80'h0;
    localparam logic [79:0] N_ZERO = {1'b1, 79'h0};
    localparam logic [79:0] P_INF  = {1'b0, 15'h7FFF, 64'h8000_0000_0000_0000};
    localparam logic [79:0] Q_NAN  = {1'b0, 15'h7FFF, 64'hC000_0000_0000_0000};

    typedef struct packed {
        logic [1:0]  mode;
        logic [79:0] a;
        logic [79:0] b;
        logic [2:0]  code;   // {bit14, bit10, bit8}
        logic [1:0]  pop;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{2'd0, P_ONE,  P_TWO,  3'b001, 2'd0, 4'd2},   // R2
        '{2'd0, P_TWO,  P_ONE,  3'b000, 2'd0, 4'd4},   // R4
        '{2'd0, P_ONE,  P_ONE,  3'b100, 2'd0, 4'd3},   // R3
        '{2'd0, P_ZERO, N_ZERO, 3'b100, 2'd0, 4'd3},   // R3 signed zeros
        '{2'd1, Q_NAN,  P_ONE,  3'b111, 2'd1, 4'd5},   // R5
        '{2'd2, P_ONE,  Q_NAN,  3'b111, 2'd2, 4'd5},   // R5 and R8
        '{2'd0, P_INF,  P_TWO,  3'b000, 2'd0, 4'd5},   // R5 infinity ordered
        '{2'd0, N_ONE,  N_TWO,  3'b000, 2'd0, 4'd6},   // R6 exponent, negative
        '{2'd0, N_TWO,  P_ONE,  3'b001, 2'd0, 4'd6},   // R6 sign
        '{2'd0, P_ONE,  P_1P5,  3'b001, 2'd0, 4'd6},   // R6 significand
        '{2'd0, N_1P5,  N_ONE,  3'b001, 2'd0, 4'd6},   // R6 significand, negative
        '{2'd3, N_ONE,  P_TWO,  3'b001, 2'd0, 4'd7},   // R7
        '{2'd3, N_ZERO, Q_NAN,  3'b100, 2'd0, 4'd7},   // R7 opb ignored
        '{2'd3, P_1P5,  Q_NAN,  3'b000, 2'd0, 4'd7},   // R7
        '{2'd1, P_TWO,  N_ONE,  3'b000, 2'd1, 4'd8}    // R8
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmp_valid = 1'b0;
    logic [1:0]  cmp_mode = 2'd0;
    logic [79:0] opa = '0;
    logic [79:0] opb = '0;
    logic [15:0] status_in = '0;
    logic [15:0] status_q;
    logic [1:0]  pop_q;

    int n_checks = 0;
    int n_fails  = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fcmp_status_unit dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmp_valid (cmp_valid),
        .cmp_mode  (cmp_mode),
        .opa       (opa),
        .opb       (opb),
        .status_in (status_in),
        .status_q  (status_q),
        .pop_q     (pop_q)
    );

    function automatic logic [15:0] merge(input logic [15:0] s, input logic [2:0] c);
        return (s & 16'hBAFF) | {1'b0, c[2], 3'b000, c[1], 1'b0, c[0], 8'h00};
    endfunction

    task automatic check16(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [1:0] m, input logic [79:0] a, input logic [79:0] b,
                          input logic [15:0] s);
        @(negedge clk);
        cmp_valid = 1'b1; cmp_mode = m; opa = a; opb = b; status_in = s;
        @(negedge clk);
        cmp_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check16("R1 status", status_q, 16'h0000);
        check16("R1 pop", {14'h0, pop_q}, 16'h0000);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [15:0] s;
            s = 16'hFFFF ^ 16'(i * 16'h1357);
            run_op(VECS[i].mode, VECS[i].a, VECS[i].b, s);
            // R9: surrounding bits come from status_in
            check16($sformatf("R%0d/R9 vec %0d status", VECS[i].req, i),
                    status_q, merge(s, VECS[i].code));
            check16($sformatf("R8 vec %0d pop", i), {14'h0, pop_q}, {14'h0, VECS[i].pop});
        end

        // R10: idle cycles hold status while status_in moves; R8 pop returns to 0
        run_op(2'd0, P_ONE, P_TWO, 16'h1234);
        check16("R10 after op", status_q, merge(16'h1234, 3'b001));
        status_in = 16'hFFFF; opa = Q_NAN;
        repeat (3) @(negedge clk);
        check16("R10 hold", status_q, merge(16'h1234, 3'b001));
        check16("R8 idle pop", {14'h0, pop_q}, 16'h0000);

        // R3 negative zero against positive zero, reversed order
        run_op(2'd0, N_ZERO, P_ZERO, 16'h0000);
        check16("R3 -0 vs +0", status_q, 16'h4000);

        // R5 NaN with integer bit clear but low fraction set
        run_op(2'd0, P_ONE, {1'b1, 15'h7FFF, 64'h0000_0000_0000_0001}, 16'h0000);
        check16("R5 low-fraction NaN", status_q, 16'h4500);

        // R1 reset mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check16("R1 re-reset", status_q, 16'h0000);
        rst_n = 1'b1;

        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule